// File: doc/BRIEF.md
# Memory-Mapped Multiply-Accumulate Unit

This block is a 16-bit hardware multiplier that sits on a simple processor peripheral bus. Software picks the arithmetic operation by choosing which of four aliased operand-1 addresses it writes. Those four addresses select unsigned multiply, signed multiply, unsigned accumulate and signed accumulate. All four store into the same operand-1 register. Writing operand 2 starts the operation. One clock later the 32-bit result sits in a pair of result words, and a read-only extension word holds either a sign or a carry.

Every storage register reads back what was last written to it. The bus carries a two-bit byte-enable. A one-lane write is a byte write: it stores the selected byte in the low half of the target register and clears the upper half. Reads are combinational from the address presented with the read strobe.

Top module: `mac_periph`

## Requirements
- R1: After reset, every register (operand 1, operand 2, result low, result high, extension) reads 0x0000.
- R2: Word indices 0, 1, 2 and 3 share one operand-1 register. A 16-bit write (`bus_we`=2'b11) through any of them reads back the same value at all four indices.
- R3: Operand 2 is at index 4 and reads back the last value written to it.
- R4: A byte write (`bus_we`=2'b01 takes `bus_wdata[7:0]`, 2'b10 takes `bus_wdata[15:8]`) to operand 1, operand 2, result low or result high stores that byte in bits 7:0 and clears bits 15:8.
- R5: Result low (index 5) and result high (index 6) can be written directly by software and read back the written value.
- R6: Mode 0, set by an operand-1 write at index 0, forms the unsigned 32-bit product into result high:low, and the extension word (index 7) becomes 0x0000.
- R7: Mode 1, set at index 1, forms the two's-complement product. The extension word becomes 0xFFFF when result bit 31 is set and 0x0000 otherwise.
- R8: Mode 2, set at index 2, adds the unsigned product to the current 32-bit result modulo 2^32. The extension word becomes the carry out of that addition (0x0000 or 0x0001).
- R9: Mode 3, set at index 3, adds the signed product to the current result. The extension word becomes 0xFFFF or 0x0000 according to the new result bit 31.
- R10: A write to operand 2 starts an operation. A read in the cycle after that write still returns the old result, and the new result is visible one clock later. The mode is the one latched by the most recent operand-1 write, and it holds across several operand-2 writes.
- R11: Writes to the extension word at index 7 have no effect on its value.
- R12: While `bus_re` is low, `bus_rdata` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word index of the register accessed |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 2 | Byte-lane write enables; 11 = word, 01/10 = byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |

## Verification
The hardest cases to reach are the accumulate carry and sign cases. They need the result pair preset to values near the 32-bit wrap before the multiply-add runs. The bench therefore writes result low and high directly before every accumulate in its sweep, with a preset built from the operands. It then sweeps all operand pairs from a set of edge values, including 0x8000 and 0xFFFF, in all four modes. Each operation is read once in the cycle straight after the operand-2 write, to confirm the old result is still there, and again one clock later for the new result.

// File: rtl/mac_periph.sv
module mac_periph #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   bus_addr,
  input  logic         bus_re,
  input  logic [1:0]   bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata
);
  localparam int RW = 2 * W;
  localparam int HB = W / 2;

  logic [W-1:0] op1, op2, res_lo, res_hi, ext;
  logic [1:0]   mode;
  logic         start;

  logic         wr;
  logic [W-1:0] wval;
  assign wr   = |bus_we;
  assign wval = (bus_we == 2'b11) ? bus_wdata :
                bus_we[0] ? {{(W-HB){1'b0}}, bus_wdata[HB-1:0]} :
                            {{(W-HB){1'b0}}, bus_wdata[W-1:HB]};

  logic op1_wr, op2_wr, lo_wr, hi_wr;
  assign op1_wr = wr && !bus_addr[2];
  assign op2_wr = wr && bus_addr == 3'd4;
  assign lo_wr  = wr && bus_addr == 3'd5;
  assign hi_wr  = wr && bus_addr == 3'd6;

  logic signed [W:0]      a_x, b_x;
  logic signed [2*W+1:0]  prod_full;
  logic [RW-1:0]          prod, acc_in;
  logic [RW:0]            sum;
  logic [W-1:0]           ext_nx;

  assign a_x       = {mode[0] & op1[W-1], op1};
  assign b_x       = {mode[0] & op2[W-1], op2};
  assign prod_full = a_x * b_x;
  assign prod      = prod_full[RW-1:0];
  assign acc_in    = mode[1] ? {res_hi, res_lo} : '0;
  assign sum       = {1'b0, acc_in} + {1'b0, prod};

  always_comb begin
    case (mode)
      2'd0:    ext_nx = '0;
      2'd2:    ext_nx = {{(W-1){1'b0}}, sum[RW]};
      default: ext_nx = {W{sum[RW-1]}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1 <= '0; op2 <= '0; mode <= '0; start <= 1'b0;
    end else begin
      start <= op2_wr;
      if (op1_wr) begin
        op1  <= wval;
        mode <= bus_addr[1:0];
      end
      if (op2_wr) op2 <= wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo <= '0; res_hi <= '0; ext <= '0;
    end else if (start) begin
      res_lo <= sum[W-1:0];
      res_hi <= sum[RW-1:W];
      ext    <= ext_nx;
    end else begin
      if (lo_wr) res_lo <= wval;
      if (hi_wr) res_hi <= wval;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        3'd0, 3'd1, 3'd2, 3'd3: bus_rdata = op1;
        3'd4:    bus_rdata = op2;
        3'd5:    bus_rdata = res_lo;
        3'd6:    bus_rdata = res_hi;
        default: bus_rdata = ext;
      endcase
    end
  end

  p_umul_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && mode == 2'd0 |=> {res_hi, res_lo} ==
      ({{W{1'b0}}, $past(op1)} * {{W{1'b0}}, $past(op2)}) && ext == '0);

  p_sign_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && mode[0] |=> ext == {W{res_hi[W-1]}});

  p_carry_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && mode == 2'd2 |=> ext == '0 || ext == {{(W-1){1'b0}}, 1'b1});

  p_ext_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ext));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && !bus_addr[2]) |=> $stable(mode));

  p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == '0);
endmodule

// File: tb/mac_periph_test.sv
`timescale 1ns/1ps
module mac_periph_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  bus_addr = 0;
  logic        bus_re = 0;
  logic [1:0]  bus_we = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;

  int vectors = 0;
  int miscompares = 0;

  mac_periph uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
                  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_addr = a; bus_we = be; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    bus_re = 0;
  endtask

  function automatic logic [31:0] mul(input logic [1:0] m, input logic [15:0] a, input logic [15:0] b);
    if (m[0]) mul = 32'(longint'($signed(a)) * longint'($signed(b)));
    else      mul = 32'(longint'(a) * longint'(b));
  endfunction

  initial begin
    #(5.0 * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                            16'h8000, 16'h8001, 16'hFFFF, 16'h1234};

  initial begin
    logic [15:0] d;
    logic [31:0] res, p, pre;
    logic [32:0] s;
    logic [15:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R1 reset", d, 16'h0000);
    end

    for (int a = 0; a < 4; a++) begin
      wr(3'(a), 16'hA5C0 + 16'(a), 2'b11);
      for (int b = 0; b < 4; b++) begin
        rd(3'(b), d); check("R2 alias", d, 16'hA5C0 + 16'(a));
      end
    end
    wr(3'd4, 16'h5678, 2'b11);
    @(posedge clk);
    rd(3'd4, d); check("R3 op2", d, 16'h5678);

    @(negedge clk); bus_addr = 3'd4; bus_re = 0; #1;
    check("R12 idle read", bus_rdata, 16'h0000);

    for (int a = 0; a < 7; a++) begin
      if (a == 4) begin
        wr(3'd4, 16'h12AB, 2'b01); @(posedge clk);
      end else if (a != 5 && a != 6) wr(3'(a), 16'h12AB, 2'b01);
      else wr(3'(a), 16'h12AB, 2'b01);
      rd(3'(a), d); check("R4 byte low lane", d, 16'h00AB);
      if (a == 4) begin
        wr(3'd4, 16'hCD34, 2'b10); @(posedge clk);
      end else wr(3'(a), 16'hCD34, 2'b10);
      rd(3'(a), d); check("R4 byte high lane", d, 16'h00CD);
    end

    wr(3'd5, 16'h8765, 2'b11); rd(3'd5, d); check("R5 res lo", d, 16'h8765);
    wr(3'd6, 16'hCBA9, 2'b11); rd(3'd6, d); check("R5 res hi", d, 16'hCBA9);
    res = 32'hCBA98765;
    rd(3'd7, e);
    wr(3'd7, 16'h1234, 2'b11); rd(3'd7, d); check("R11 ext write ignored", d, e);

    wr(3'd1, 16'hFFFF, 2'b11);
    wr(3'd4, 16'hFFFF, 2'b11); @(posedge clk);
    wr(3'd4, 16'h0002, 2'b11);
    rd(3'd5, d); check("R10 old lo", d, 16'h0001);
    @(posedge clk);
    rd(3'd5, d); check("R10 mode held lo", d, 16'hFFFE);
    rd(3'd6, d); check("R10 mode held hi", d, 16'hFFFF);
    rd(3'd7, d); check("R10 mode held ext", d, 16'hFFFF);
    wr(3'd7, 16'h0000, 2'b11); rd(3'd7, d); check("R11 ext write ignored", d, 16'hFFFF);
    res = 32'hFFFFFFFE;

    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          if (m >= 2) begin
            pre = {vals[j], vals[i]} ^ 32'h5A5A0F0F;
            if ((i + j) % 3 == 0) pre = 32'hFFFFFFFF - 32'(i);
            wr(3'd5, pre[15:0], 2'b11);
            wr(3'd6, pre[31:16], 2'b11);
            res = pre;
          end
          wr(3'(m), vals[i], 2'b11);
          wr(3'd4, vals[j], 2'b11);
          rd(3'd5, d); check("R10 old result", d, res[15:0]);
          @(posedge clk);
          p = mul(2'(m), vals[i], vals[j]);
          s = (m >= 2) ? {1'b0, res} + {1'b0, p} : {1'b0, p};
          res = s[31:0];
          case (m)
            0: e = 16'h0000;
            2: e = {15'd0, s[32]};
            default: e = {16{s[31]}};
          endcase
          rd(3'd5, d);
          check(m == 0 ? "R6 lo" : m == 1 ? "R7 lo" : m == 2 ? "R8 lo" : "R9 lo", d, res[15:0]);
          rd(3'd6, d);
          check(m == 0 ? "R6 hi" : m == 1 ? "R7 hi" : m == 2 ? "R8 hi" : "R9 hi", d, res[31:16]);
          rd(3'd7, d);
          check(m == 0 ? "R6 ext" : m == 1 ? "R7 ext" : m == 2 ? "R8 ext" : "R9 ext", d, e);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule